// File: doc/BRIEF.md
# Single-Wire Link Session Controller

This block is the device-side session manager of a half-duplex single-wire link. A token decoder in front of it turns line activity into two kinds of event: a wake event, and a strobe that carries one received data bit. The controller groups received bits into 8-bit flag codes, least significant bit first, and reacts to them. It moves the device between five activities: sleeping, waiting awake for a flag, receiving a command block, busy while a command engine runs, and handing the line to a response transmitter.

A command flag routes the following bits to the command engine one by one. The first byte of the block gives its total length in bytes, and the controller counts the block to its end. It then pulses a start request and waits for the engine to report completion. A transmit flag starts a turnaround interval, after which the transmitter is asked to send either the wake status byte or the stored command response. Two supervisors run beside this. An inter-token timeout sends the device back to sleep when the line goes quiet while it is expecting bits. A watchdog counts from wake and forces sleep whatever the device is doing. Every duration is a clock-cycle parameter.

Top module: `swl_session`

## Requirements
- R1: After reset the device is asleep (`sess_awake`=0, `sess_busy`=0), and `cmd_go`, `tx_go`, `cmd_bit_vld` and `sleep_rst` are all 0.
- R2: While asleep, bit strobes have no effect and only `wake_evt` makes the device awake (`sess_awake`=1 after the wake edge).
- R3: Flag bits are assembled least significant bit first: the first strobed bit after an idle state becomes bit 0 of the 8-bit code.
- R4: A flag code other than 0x77, 0x88 or 0xCC is ignored: the device stays awake and idle, nothing is requested, and flag alignment continues with the next eight bits.
- R5: Flag 0xCC puts the device to sleep at the edge of its eighth bit, with a one-cycle `sleep_rst` pulse. Every entry into sleep gives this pulse.
- R6: After flag 0x77, each received bit is forwarded on `cmd_bit`/`cmd_bit_vld` in the cycle after its strobe. The first forwarded byte (LSB first) is the block length in bytes, clamped to the range MIN_BLK..MAX_BLK (defaults 4 and 39). On the last bit of that length, `cmd_go` pulses and `sess_busy` rises.
- R7: While busy, bit strobes are ignored (a transmit flag gives no `tx_go`) and the timeout does not run. `exec_done` returns the device to awake.
- R8: `tx_status`=1 marks the wake status response (0x11); it is used for any transmit flag before the first command since wake. After a command has run, `tx_status`=0 for every transmit flag, so the response can be re-sent repeatedly.
- R9: After the eighth bit of flag 0x88, `tx_go` pulses exactly TURN_CYC edges later. The device then stays in transmit until `tx_done`.
- R10: While awake-idle or receiving a command, the device sleeps at the TIMEOUT_CYC-th edge after the last wake, token, `exec_done` or `tx_done` if no token arrives on that edge.
- R11: The watchdog forces sleep at the WATCHDOG_CYC-th edge after the wake edge, regardless of state; only sleep and a new wake restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_evt | input | 1 | Wake token seen by the decoder (one cycle) |
| bit_stb | input | 1 | Received data bit strobe (one cycle) |
| bit_val | input | 1 | Value of the strobed bit |
| exec_done | input | 1 | Command engine finished the current command |
| tx_done | input | 1 | Response transmitter finished sending |
| sess_awake | output | 1 | Device is out of sleep |
| sess_busy | output | 1 | A command is executing |
| cmd_bit_vld | output | 1 | A command block bit is presented |
| cmd_bit | output | 1 | The presented command block bit |
| cmd_go | output | 1 | One-cycle pulse: command block complete, start execution |
| tx_go | output | 1 | One-cycle pulse: start the response transmission |
| tx_status | output | 1 | With `tx_go`: 1 sends the wake status, 0 the command response |
| sleep_rst | output | 1 | One-cycle pulse on entry into sleep, resets engine and buffers |

## Verification
The hardest situation to reach is the watchdog firing on its exact edge. The timeout otherwise ends every session long before, so the stimulus parks the device in the busy state, where the timeout is suspended. There it withholds `exec_done` and counts edges from the wake. The timeout boundary is reached by holding the line silent for exactly one cycle less and exactly as long as the limit after a token. Random command blocks with arbitrary length bytes, including ones below and above the legal range, reach the clamp edges of the block counter.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_AWAKE = 3'd1,
    ST_RXCMD = 3'd2,
    ST_BUSY  = 3'd3,
    ST_TURN  = 3'd4,
    ST_TX    = 3'd5
  } sess_st_t;

  localparam logic [7:0] FLG_CMD   = 8'h77;
  localparam logic [7:0] FLG_XMIT  = 8'h88;
  localparam logic [7:0] FLG_SLEEP = 8'hCC;
endpackage

// File: rtl/swl_interval.sv
// Up-counting interval timer: expire is raised on the LIMIT-th enabled edge
// after a restart.
module swl_interval #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (en && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swl_flag_rx.sv
// Assembles 8-bit flag codes, first bit into bit 0.
module swl_flag_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       stb,
  input  logic       val,
  output logic       done,
  output logic [7:0] code
);
  logic [7:0] sr;
  logic [2:0] nbits;

  assign code = {val, sr[7:1]};
  assign done = stb && (nbits == 3'd7);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr    <= '0;
      nbits <= '0;
    end else if (stb) begin
      sr    <= code;
      nbits <= nbits + 1'b1;
    end
  end
endmodule

// File: rtl/swl_blk_len.sv
// Counts the bits of a command block whose first byte is its length.
module swl_blk_len #(
  parameter int MIN_BLK = 4,
  parameter int MAX_BLK = 39
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic val,
  output logic last
);
  localparam int BW = $clog2(MAX_BLK * 8 + 1);

  logic [BW-1:0] bitcnt;
  logic [BW-1:0] tot_bits;
  logic [7:0]    len_sr;
  logic [7:0]    len_byte;

  function automatic logic [BW-1:0] len_to_bits(input logic [7:0] c);
    int n;
    n = int'(c);
    if (n < MIN_BLK) n = MIN_BLK;
    else if (n > MAX_BLK) n = MAX_BLK;
    return BW'(n * 8);
  endfunction

  assign len_byte = {val, len_sr[7:1]};
  assign last = stb && (bitcnt >= BW'(8)) && ((bitcnt + BW'(1)) == tot_bits);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bitcnt   <= '0;
      tot_bits <= '0;
      len_sr   <= '0;
    end else if (stb) begin
      bitcnt <= bitcnt + BW'(1);
      if (bitcnt < BW'(8)) begin
        len_sr <= len_byte;
      end
      if (bitcnt == BW'(7)) begin
        tot_bits <= len_to_bits(len_byte);
      end
    end
  end
endmodule

// File: rtl/swl_session.sv
module swl_session #(
  parameter int TIMEOUT_CYC  = 65000,
  parameter int WATCHDOG_CYC = 4000000,
  parameter int TURN_CYC     = 600,
  parameter int MIN_BLK      = 4,
  parameter int MAX_BLK      = 39
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_evt,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic exec_done,
  input  logic tx_done,
  output logic sess_awake,
  output logic sess_busy,
  output logic cmd_bit_vld,
  output logic cmd_bit,
  output logic cmd_go,
  output logic tx_go,
  output logic tx_status,
  output logic sleep_rst
);
  import swl_pkg::*;

  sess_st_t st, nxt;
  logic       cmd_seen;
  logic       go_cmd, go_tx;
  logic       tok;
  logic       flag_done;
  logic [7:0] flag_code;
  logic       blk_last;
  logic       to_restart, to_en, to_exp;
  logic       wd_restart, wd_en, wd_exp;
  logic       tt_restart, tt_en, tt_exp;

  // A token is a bit strobe taken while the link expects bits.
  assign tok = bit_stb && ((st == ST_AWAKE) || (st == ST_RXCMD));

  swl_flag_rx u_flag (
    .clk  (clk),
    .rst  (rst),
    .clr  (st != ST_AWAKE),
    .stb  (bit_stb && (st == ST_AWAKE)),
    .val  (bit_val),
    .done (flag_done),
    .code (flag_code)
  );

  swl_blk_len #(
    .MIN_BLK (MIN_BLK),
    .MAX_BLK (MAX_BLK)
  ) u_blk (
    .clk  (clk),
    .rst  (rst),
    .clr  (st != ST_RXCMD),
    .stb  (bit_stb && (st == ST_RXCMD)),
    .val  (bit_val),
    .last (blk_last)
  );

  // Inter-token timeout: runs only while bits are expected.
  assign to_restart = ((st == ST_SLEEP) && wake_evt) || tok ||
                      ((st == ST_BUSY) && exec_done) ||
                      ((st == ST_TX) && tx_done);
  assign to_en      = ((st == ST_AWAKE) || (st == ST_RXCMD)) && !tok;

  // Watchdog: started by wake, runs in every non-sleep state.
  assign wd_restart = (st == ST_SLEEP) && wake_evt;
  assign wd_en      = (st != ST_SLEEP);

  // Turnaround before a response.
  assign tt_restart = (st != ST_TURN);
  assign tt_en      = (st == ST_TURN);

  swl_interval #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk (clk), .rst (rst), .restart (to_restart), .en (to_en), .expire (to_exp)
  );

  swl_interval #(.LIMIT(WATCHDOG_CYC)) u_wdg (
    .clk (clk), .rst (rst), .restart (wd_restart), .en (wd_en), .expire (wd_exp)
  );

  swl_interval #(.LIMIT(TURN_CYC)) u_turn (
    .clk (clk), .rst (rst), .restart (tt_restart), .en (tt_en), .expire (tt_exp)
  );

  always_comb begin
    nxt    = st;
    go_cmd = 1'b0;
    go_tx  = 1'b0;
    unique case (st)
      ST_SLEEP: if (wake_evt) nxt = ST_AWAKE;
      ST_AWAKE: begin
        if (flag_done) begin
          if (flag_code == FLG_CMD)        nxt = ST_RXCMD;
          else if (flag_code == FLG_XMIT)  nxt = ST_TURN;
          else if (flag_code == FLG_SLEEP) nxt = ST_SLEEP;
        end
      end
      ST_RXCMD: begin
        if (blk_last) begin
          nxt    = ST_BUSY;
          go_cmd = 1'b1;
        end
      end
      ST_BUSY: if (exec_done) nxt = ST_AWAKE;
      ST_TURN: begin
        if (tt_exp) begin
          nxt   = ST_TX;
          go_tx = 1'b1;
        end
      end
      ST_TX:   if (tx_done) nxt = ST_AWAKE;
      default: nxt = ST_SLEEP;
    endcase
    if ((st != ST_SLEEP) && (wd_exp || to_exp)) begin
      nxt    = ST_SLEEP;
      go_cmd = 1'b0;
      go_tx  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_SLEEP;
      cmd_seen    <= 1'b0;
      cmd_go      <= 1'b0;
      tx_go       <= 1'b0;
      tx_status   <= 1'b0;
      sleep_rst   <= 1'b0;
      cmd_bit_vld <= 1'b0;
      cmd_bit     <= 1'b0;
    end else begin
      st          <= nxt;
      cmd_go      <= go_cmd;
      tx_go       <= go_tx;
      sleep_rst   <= (st != ST_SLEEP) && (nxt == ST_SLEEP);
      cmd_bit_vld <= (st == ST_RXCMD) && bit_stb && (nxt != ST_SLEEP || blk_last) && !wd_exp;
      if (bit_stb) begin
        cmd_bit <= bit_val;
      end
      if (go_tx) begin
        tx_status <= !cmd_seen;
      end
      if (nxt == ST_SLEEP) begin
        cmd_seen <= 1'b0;
      end else if (go_cmd) begin
        cmd_seen <= 1'b1;
      end
    end
  end

  assign sess_awake = (st != ST_SLEEP);
  assign sess_busy  = (st == ST_BUSY);
endmodule

// File: rtl/swl_session_chk.sv
module swl_session_chk #(
  parameter int WATCHDOG_CYC = 4000000
) (
  input logic clk,
  input logic rst,
  input logic wake_evt,
  input logic bit_stb,
  input logic bit_val,
  input logic sess_awake,
  input logic sess_busy,
  input logic cmd_bit_vld,
  input logic cmd_bit,
  input logic cmd_go,
  input logic tx_go,
  input logic sleep_rst
);
  localparam int WW = $clog2(WATCHDOG_CYC + 1) + 1;
  logic [WW-1:0] awake_edges;

  always_ff @(posedge clk) begin
    if (rst || !sess_awake) begin
      awake_edges <= '0;
    end else begin
      awake_edges <= awake_edges + 1'b1;
    end
  end

  // R11: no session outlives the watchdog window
  always_ff @(posedge clk) begin
    if (!rst && sess_awake) begin
      assert_wdg_window_R11: assert (awake_edges < WW'(WATCHDOG_CYC))
        else $error("session exceeded watchdog window");
    end
  end

  // R2: without wake, sleep persists
  assert_sleep_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!sess_awake && !wake_evt) |=> !sess_awake);

  // R5: the reset pulse marks entry into sleep
  assert_sleep_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    sleep_rst |-> !sess_awake);

  // R6: command start coincides with busy
  assert_go_busy_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> sess_busy);

  // R6: forwarded bits follow the strobe by one cycle
  assert_fwd_bit_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_bit_vld |-> ($past(bit_stb) && (cmd_bit == $past(bit_val))));

  // R7: busy never leads straight into a transmission
  assert_busy_no_tx_R7: assert property (@(posedge clk) disable iff (rst)
    sess_busy |=> !tx_go);

  // R9: requests are exclusive
  assert_one_req_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_go, tx_go, sleep_rst}));
endmodule

bind swl_session swl_session_chk #(.WATCHDOG_CYC(WATCHDOG_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wake_evt    (wake_evt),
  .bit_stb     (bit_stb),
  .bit_val     (bit_val),
  .sess_awake  (sess_awake),
  .sess_busy   (sess_busy),
  .cmd_bit_vld (cmd_bit_vld),
  .cmd_bit     (cmd_bit),
  .cmd_go      (cmd_go),
  .tx_go       (tx_go),
  .sleep_rst   (sleep_rst)
);

// File: tb/swl_session_test.sv
module swl_session_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 20;
  localparam int WD  = 2000;
  localparam int TT  = 3;
  localparam int MNB = 4;
  localparam int MXB = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_evt = 1'b0, bit_stb = 1'b0, bit_val = 1'b0;
  logic exec_done = 1'b0, tx_done = 1'b0;
  logic sess_awake, sess_busy, cmd_bit_vld, cmd_bit, cmd_go, tx_go, tx_status, sleep_rst;

  int vectors = 0;
  int errors  = 0;
  int edges   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swl_session #(
    .TIMEOUT_CYC (TO), .WATCHDOG_CYC (WD), .TURN_CYC (TT),
    .MIN_BLK (MNB), .MAX_BLK (MXB)
  ) uut (
    .clk (clk), .rst (rst), .wake_evt (wake_evt), .bit_stb (bit_stb),
    .bit_val (bit_val), .exec_done (exec_done), .tx_done (tx_done),
    .sess_awake (sess_awake), .sess_busy (sess_busy), .cmd_bit_vld (cmd_bit_vld),
    .cmd_bit (cmd_bit), .cmd_go (cmd_go), .tx_go (tx_go), .tx_status (tx_status),
    .sleep_rst (sleep_rst)
  );

  function automatic int exp_len(input int c);
    if (c < MNB) return MNB;
    if (c > MXB) return MXB;
    return c;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic s, input logic v,
                      input logic ed, input logic td);
    wake_evt = w; bit_stb = s; bit_val = v; exec_done = ed; tx_done = td;
    @(posedge clk);
    @(negedge clk);
    wake_evt = 0; bit_stb = 0; bit_val = 0; exec_done = 0; tx_done = 0;
    edges++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
  endtask

  task automatic do_wake();
    tick(1, 0, 0, 0, 0);
    edges = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) tick(0, 1, b[i], 0, 0);
  endtask

  // Sends a block after the command flag; checks forwarding and the go pulse.
  task automatic send_block(input int cnt, input int gapmax, input string tag);
    int n;
    logic [7:0] b;
    n = exp_len(cnt);
    for (int k = 0; k < n; k++) begin
      b = (k == 0) ? 8'(cnt) : 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        if (gapmax > 0) idle($urandom % (gapmax + 1));
        tick(0, 1, b[i], 0, 0);
        chk(cmd_bit_vld, 1, {tag, " R6 forwarded valid"});
        chk(cmd_bit, b[i], {tag, " R6 forwarded value"});
        chk(cmd_go, (k == n - 1 && i == 7) ? 1 : 0, {tag, " R6 go at block end"});
      end
    end
    chk(sess_busy, 1, {tag, " R6 busy after block"});
  endtask

  task automatic expect_tx(input int status, input string tag);
    send_byte(8'h88);
    for (int i = 0; i < TT - 1; i++) begin
      tick(0, 0, 0, 0, 0);
      chk(tx_go, 0, {tag, " R9 turnaround not yet over"});
    end
    tick(0, 0, 0, 0, 0);
    chk(tx_go, 1, {tag, " R9 tx_go after turnaround"});
    chk(tx_status, status, {tag, " R8 response selection"});
    tick(0, 0, 0, 0, 1);
    chk(sess_awake, 1, {tag, " R9 awake after tx_done"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(sess_awake, 0, "R1 asleep");
    chk(sess_busy, 0, "R1 not busy");
    chk(cmd_go | tx_go | cmd_bit_vld | sleep_rst, 0, "R1 no pulses");

    // R2 strobes while asleep are ignored
    send_byte(8'h77);
    send_byte(8'h88);
    chk(sess_awake, 0, "R2 strobes keep sleep");
    chk(tx_go | cmd_bit_vld, 0, "R2 no activity in sleep");
    do_wake();
    chk(sess_awake, 1, "R2 wake leaves sleep");

    // R3 LSB-first flag, R8 wake status
    expect_tx(1, "R3");

    // R4 reserved flag ignored, alignment kept
    send_byte(8'h11);
    idle(TT + 1);
    chk(sess_awake, 1, "R4 awake after reserved flag");
    chk(tx_go | cmd_bit_vld | sess_busy, 0, "R4 nothing requested");
    expect_tx(1, "R4");

    // R6 command block
    send_byte(8'h77);
    send_block(5, 0, "dir");

    // R7 busy: transmit ignored, timeout suspended
    send_byte(8'h88);
    idle(TT + 2);
    chk(tx_go, 0, "R7 transmit ignored while busy");
    idle(TO + 5);
    chk(sess_awake, 1, "R7 timeout suspended while busy");
    chk(sess_busy, 1, "R7 still busy");
    tick(0, 0, 0, 1, 0);
    chk(sess_busy, 0, "R7 exec_done ends busy");

    // R8 response, re-sent
    expect_tx(0, "R8a");
    expect_tx(0, "R8b");

    // R10 timeout boundary
    tick(0, 1, 1, 0, 0);
    idle(TO - 1);
    chk(sess_awake, 1, "R10 awake one cycle before limit");
    idle(1);
    chk(sess_awake, 0, "R10 asleep at limit");
    chk(sleep_rst, 1, "R10 sleep pulse");
    do_wake();
    idle(TO);
    chk(sess_awake, 0, "R10 timeout after wake with no token");

    // R5 sleep flag, then status restored
    do_wake();
    send_byte(8'hCC);
    chk(sess_awake, 0, "R5 sleep flag");
    chk(sleep_rst, 1, "R5 sleep pulse");
    tick(0, 0, 0, 0, 0);
    chk(sleep_rst, 0, "R5 pulse is one cycle");
    do_wake();
    expect_tx(1, "R5");

    // R11 watchdog while busy
    idle(TO + 1);
    do_wake();
    send_byte(8'h77);
    send_block(2, 0, "wdg");
    while (edges < WD - 1) tick(0, 0, 0, 0, 0);
    chk(sess_busy, 1, "R11 busy before watchdog edge");
    tick(0, 0, 0, 0, 0);
    chk(sess_awake, 0, "R11 watchdog forces sleep");
    chk(sleep_rst, 1, "R11 sleep pulse");

    // Random sessions
    for (int it = 0; it < 30; it++) begin
      do_wake();
      if ($urandom % 2) begin
        logic [7:0] r;
        r = 8'($urandom);
        if (r == 8'h77 || r == 8'h88 || r == 8'hCC) r = 8'h00;
        send_byte(r);
        chk(sess_awake, 1, "R4 random reserved flag");
      end
      send_byte(8'h77);
      send_block(int'($urandom % 64), 2, "rnd");
      tick(0, 0, 0, 1, 0);
      expect_tx(0, "R8 rnd");
      send_byte(8'hCC);
      chk(sess_awake, 0, "R5 random sleep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule